// File: doc/BRIEF.md
# Three-Phase Instruction Sequencer and Decoder

This block steers a 16-bit load/store processor through its instruction cycle. A two-bit phase register walks through fetch, constant capture and execute. When the fetched word needs no trailing constant, the constant-capture step is skipped. A one-bit in-service flag guards a single level of vectored interrupt. From the phase, the flag, the latched instruction word and a few status inputs, the block drives every select and write-enable that the datapath needs. The register file, ALU and memory sit outside the block.

All datapath controls are combinational functions of the current phase, the flag and the inputs. Only the phase and the flag are registered. The block has no streaming traffic, so every pin is a plain level signal and there is no valid/ready handshake or back-pressure. The reset input is sampled synchronously. While it is high it overrides every other input.

Instruction word layout, from the top bit down:
- `[15:11]` ALU function.
- `[10]` constant-needed.
- `[9]` non-ALU class.
- `[8:6]` second source register, or the operation code when bit 9 is set.
- `[5:3]` destination register.
- `[2:0]` first source register.

The operation codes with bit 9 set are:

| Code | Operation |
|------|-----------|
| 000 | indirect jump |
| 010 | load |
| 011 | store |
| 100 | branch-if-zero |
| 101 | branch-if-nonzero |
| 110 | PC-relative load |
| 001, 111 | undefined |

Top module: `cpu_ctrl`

## Requirements
- R1: While `rst` is high: `pc_sel`=2, `vec_irq`=0, `rf_we`=0, `mem_we`=0, `flag_we`=0, and every other select is 0. On the following cycle the phase is fetch and the flag is clear.
- R2: Fetch phase with no accepted interrupt: `instr_load`=1, no write, and `maddr_from_alu`=0. If `const_need`=0, then `pc_sel`=0 (hold) and the next phase is execute. If `const_need`=1, then `pc_sel`=1 (PC+2) and the next phase is constant capture.
- R3: Constant-capture phase: `instr_load`=0, `pc_sel`=0, no write, all selects 0, and the next phase is execute.
- R4: Execute phase with bit 9 = 0: `rf_we`=1, `wd_sel`=1 (ALU), `b_from_const` equal to bit 10, `pc_sel`=1, other selects 0. The next phase is fetch.
- R5: `alu_fn`, `rb`, `rc` and `ra` always equal instruction bits [15:11], [8:6], [5:3] and [2:0].
- R6: Execute phase, memory operations (`maddr_from_alu`=1, `b_from_const`=1, `pc_sel`=1 for each):
  - Load (010): `rf_we`=1, `wd_sel`=2.
  - PC-relative load (110): same as load, and also `a_from_pc`=1.
  - Store (011): `mem_we`=1, `rb_from_rc`=1, `rf_we`=0.
- R7: Execute phase, branches: `rf_we`=1, `wd_sel`=0 (PC+2), `a_from_pc`=1, `b_from_const`=1. Branch-if-zero gives `pc_sel`=3 when `zero_a`=1 and 1 otherwise. Branch-if-nonzero gives the opposite.
- R8: Execute phase, jump (000): `pc_sel`=3, `rf_we`=1, `wd_sel`=0, `b_from_const` equal to bit 10. When `ra`=6, `flag_we`=1 with `vec_irq`=0, which clears the flag for the next cycle.
- R9: Fetch phase with `irq`=1 and the flag clear: `vec_irq`=1, `flag_we`=1, `rf_we`=1, `exc_dst`=1, `wd_sel`=3 (current PC), `pc_sel`=2, `instr_load`=0. The phase stays at fetch and the flag is set on the next cycle.
- R10: `irq` has no effect when the flag is set or the phase is not fetch. The outputs are then those of R2, R3 or the execute decode.
- R11: Execute phase with undefined codes 001 or 111: no write, `pc_sel`=1, all other selects 0. The next phase is fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Interrupt request |
| zero_a | input | 1 | Register channel A equals zero |
| const_need | input | 1 | Bit 10 of the memory read data |
| instr | input | 16 | Latched instruction word |
| pc_sel | output | 2 | Next-PC source: 0 hold, 1 PC+2, 2 vector, 3 jump target |
| wd_sel | output | 2 | Register write data: 0 PC+2, 1 ALU, 2 memory, 3 PC |
| rb_from_rc | output | 1 | Channel B reads the destination field |
| exc_dst | output | 1 | Register write goes to R6 instead of the destination field |
| rf_we | output | 1 | Register file write enable |
| a_from_pc | output | 1 | ALU input A takes PC+2 |
| b_from_const | output | 1 | ALU input B takes the constant word |
| mem_we | output | 1 | Memory write enable |
| maddr_from_alu | output | 1 | Memory address from the ALU instead of the PC |
| instr_load | output | 1 | Instruction register load enable |
| alu_fn | output | 5 | ALU function field |
| ra | output | 3 | First source register |
| rb | output | 3 | Second source register |
| rc | output | 3 | Destination register |
| vec_irq | output | 1 | Vector choice: 1 interrupt, 0 reset |
| flag_we | output | 1 | In-service flag write; the value written is `vec_irq` |

## Verification
Every control output depends combinationally on the present phase, the flag and the inputs, so it is due in the same cycle that the stimulus is applied. Changes to the phase and the flag become visible one clock edge later, through the outputs of the following cycle. The bench applies inputs on the falling edge and compares all outputs 5 ns later, before the rising edge. It advances its own phase and flag model only after that rising edge. Checks therefore never straddle a register update, and each cycle checks both the decode and the state carried over from the previous cycle.

// File: rtl/cu_pkg.sv
package cu_pkg;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_CONST = 2'd1,
    PH_EXEC  = 2'd2
  } phase_e;

  localparam logic [2:0] OP_JMP = 3'b000;
  localparam logic [2:0] OP_LD  = 3'b010;
  localparam logic [2:0] OP_ST  = 3'b011;
  localparam logic [2:0] OP_BZ  = 3'b100;
  localparam logic [2:0] OP_BNZ = 3'b101;
  localparam logic [2:0] OP_LDR = 3'b110;

  localparam logic [1:0] PCS_HOLD = 2'd0;
  localparam logic [1:0] PCS_INC  = 2'd1;
  localparam logic [1:0] PCS_VEC  = 2'd2;
  localparam logic [1:0] PCS_JUMP = 2'd3;

  localparam logic [1:0] WDS_PCINC = 2'd0;
  localparam logic [1:0] WDS_ALU   = 2'd1;
  localparam logic [1:0] WDS_MEM   = 2'd2;
  localparam logic [1:0] WDS_PC    = 2'd3;

  typedef struct packed {
    logic [1:0] pc_sel;
    logic [1:0] wd_sel;
    logic       rb_from_rc;
    logic       exc_dst;
    logic       rf_we;
    logic       a_from_pc;
    logic       b_from_const;
    logic       mem_we;
    logic       maddr_from_alu;
    logic       instr_load;
    logic       vec_irq;
    logic       flag_we;
  } ctrl_t;

endpackage

// File: rtl/cu_fields.sv
module cu_fields #(
  parameter int FN_W = 5,
  parameter int RA_W = 3
) (
  input  logic [FN_W+2+3*RA_W-1:0] instr,
  output logic [FN_W-1:0]          alu_fn,
  output logic                     cbit,
  output logic                     sys,
  output logic [RA_W-1:0]          rb,
  output logic [RA_W-1:0]          rc,
  output logic [RA_W-1:0]          ra
);
  localparam int RC_LO  = RA_W;
  localparam int RB_LO  = 2 * RA_W;
  localparam int SYS_B  = 3 * RA_W;
  localparam int CB_B   = SYS_B + 1;
  localparam int FN_LO  = CB_B + 1;

  assign ra     = instr[RA_W-1:0];
  assign rc     = instr[RC_LO +: RA_W];
  assign rb     = instr[RB_LO +: RA_W];
  assign sys    = instr[SYS_B];
  assign cbit   = instr[CB_B];
  assign alu_fn = instr[FN_LO +: FN_W];
endmodule

// File: rtl/cu_exec_dec.sv
module cu_exec_dec
  import cu_pkg::*;
#(
  parameter int RA_W    = 3,
  parameter int EXC_REG = 6
) (
  input  logic            sys,
  input  logic            cbit,
  input  logic [RA_W-1:0] op,
  input  logic [RA_W-1:0] ra,
  input  logic            zero_a,
  output ctrl_t           ex
);
  always_comb begin
    ex = '0;
    if (!sys) begin
      ex.rf_we        = 1'b1;
      ex.wd_sel       = WDS_ALU;
      ex.b_from_const = cbit;
      ex.pc_sel       = PCS_INC;
    end else begin
      ex.pc_sel = PCS_INC;
      unique case (op[2:0])
        OP_JMP: begin
          ex.pc_sel       = PCS_JUMP;
          ex.rf_we        = 1'b1;
          ex.wd_sel       = WDS_PCINC;
          ex.b_from_const = cbit;
          ex.flag_we      = (ra == RA_W'(EXC_REG));
        end
        OP_LD: begin
          ex.rf_we          = 1'b1;
          ex.wd_sel         = WDS_MEM;
          ex.maddr_from_alu = 1'b1;
          ex.b_from_const   = 1'b1;
        end
        OP_LDR: begin
          ex.rf_we          = 1'b1;
          ex.wd_sel         = WDS_MEM;
          ex.maddr_from_alu = 1'b1;
          ex.a_from_pc      = 1'b1;
          ex.b_from_const   = 1'b1;
        end
        OP_ST: begin
          ex.mem_we         = 1'b1;
          ex.rb_from_rc     = 1'b1;
          ex.maddr_from_alu = 1'b1;
          ex.b_from_const   = 1'b1;
        end
        OP_BZ, OP_BNZ: begin
          ex.rf_we        = 1'b1;
          ex.wd_sel       = WDS_PCINC;
          ex.a_from_pc    = 1'b1;
          ex.b_from_const = 1'b1;
          ex.pc_sel       = ((op[0] == 1'b0) == zero_a) ? PCS_JUMP : PCS_INC;
        end
        default: ex.pc_sel = PCS_INC;
      endcase
    end
  end
endmodule

// File: rtl/cu_seq.sv
module cu_seq
  import cu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  irq,
  input  logic  const_need,
  input  ctrl_t ex,
  output ctrl_t ctl
);
  phase_e phase_q, phase_d;
  logic   flag_q;

  always_comb begin
    ctl     = '0;
    phase_d = PH_FETCH;
    if (rst) begin
      ctl.pc_sel = PCS_VEC;
    end else begin
      unique case (phase_q)
        PH_FETCH: begin
          if (irq && !flag_q) begin
            ctl.pc_sel  = PCS_VEC;
            ctl.wd_sel  = WDS_PC;
            ctl.exc_dst = 1'b1;
            ctl.rf_we   = 1'b1;
            ctl.vec_irq = 1'b1;
            ctl.flag_we = 1'b1;
          end else begin
            ctl.instr_load = 1'b1;
            ctl.pc_sel     = const_need ? PCS_INC : PCS_HOLD;
            phase_d        = const_need ? PH_CONST : PH_EXEC;
          end
        end
        PH_CONST: phase_d = PH_EXEC;
        PH_EXEC:  ctl = ex;
        default:  phase_d = PH_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FETCH;
      flag_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (ctl.flag_we) flag_q <= ctl.vec_irq;
    end
  end
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import cu_pkg::*;
#(
  parameter int FN_W    = 5,
  parameter int RA_W    = 3,
  parameter int EXC_REG = 6,
  localparam int IW     = FN_W + 2 + 3 * RA_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            irq,
  input  logic            zero_a,
  input  logic            const_need,
  input  logic [IW-1:0]   instr,
  output logic [1:0]      pc_sel,
  output logic [1:0]      wd_sel,
  output logic            rb_from_rc,
  output logic            exc_dst,
  output logic            rf_we,
  output logic            a_from_pc,
  output logic            b_from_const,
  output logic            mem_we,
  output logic            maddr_from_alu,
  output logic            instr_load,
  output logic [FN_W-1:0] alu_fn,
  output logic [RA_W-1:0] ra,
  output logic [RA_W-1:0] rb,
  output logic [RA_W-1:0] rc,
  output logic            vec_irq,
  output logic            flag_we
);
  logic  cbit, sys;
  ctrl_t ex, ctl;

  cu_fields #(.FN_W(FN_W), .RA_W(RA_W)) i_fields (
    .instr(instr), .alu_fn(alu_fn), .cbit(cbit), .sys(sys),
    .rb(rb), .rc(rc), .ra(ra)
  );

  cu_exec_dec #(.RA_W(RA_W), .EXC_REG(EXC_REG)) i_dec (
    .sys(sys), .cbit(cbit), .op(rb), .ra(ra), .zero_a(zero_a), .ex(ex)
  );

  cu_seq i_seq (
    .clk(clk), .rst(rst), .irq(irq), .const_need(const_need),
    .ex(ex), .ctl(ctl)
  );

  assign pc_sel         = ctl.pc_sel;
  assign wd_sel         = ctl.wd_sel;
  assign rb_from_rc     = ctl.rb_from_rc;
  assign exc_dst        = ctl.exc_dst;
  assign rf_we          = ctl.rf_we;
  assign a_from_pc      = ctl.a_from_pc;
  assign b_from_const   = ctl.b_from_const;
  assign mem_we         = ctl.mem_we;
  assign maddr_from_alu = ctl.maddr_from_alu;
  assign instr_load     = ctl.instr_load;
  assign vec_irq        = ctl.vec_irq;
  assign flag_we        = ctl.flag_we;
endmodule

// File: rtl/cpu_ctrl_chk.sv
module cpu_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       const_need,
  input logic [1:0] pc_sel,
  input logic       rf_we,
  input logic       mem_we,
  input logic       instr_load,
  input logic       vec_irq,
  input logic       flag_we
);
  // R1
  reset_vec_chk: assert property (@(posedge clk)
    rst |-> (pc_sel == 2'd2 && !rf_we && !mem_we && !vec_irq && !flag_we));

  // R2
  fetch_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    instr_load |-> (!rf_we && !mem_we));

  // R2
  fetch_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_load && const_need) |-> pc_sel == 2'd1);

  // R3
  single_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    instr_load |=> !instr_load);

  // R9
  irq_once_chk: assert property (@(posedge clk) disable iff (rst)
    vec_irq |=> !vec_irq);

  // R6
  wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !rf_we);
endmodule

bind cpu_ctrl cpu_ctrl_chk i_cpu_ctrl_chk (
  .clk(clk), .rst(rst), .const_need(const_need), .pc_sel(pc_sel),
  .rf_we(rf_we), .mem_we(mem_we), .instr_load(instr_load),
  .vec_irq(vec_irq), .flag_we(flag_we)
);

// File: tb/test_cpu_ctrl.sv
module test_cpu_ctrl;
  logic clk = 1'b0;
  logic rst, irq, zero_a, const_need;
  logic [15:0] instr;
  logic [1:0] pc_sel, wd_sel;
  logic rb_from_rc, exc_dst, rf_we, a_from_pc, b_from_const, mem_we;
  logic maddr_from_alu, instr_load, vec_irq, flag_we;
  logic [4:0] alu_fn;
  logic [2:0] ra, rb, rc;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model state: 0 fetch, 1 constant, 2 execute
  int ph_m = 0;
  bit fl_m = 0;

  always #10 clk = ~clk;

  cpu_ctrl i_cpu_ctrl (
    .clk(clk), .rst(rst), .irq(irq), .zero_a(zero_a), .const_need(const_need),
    .instr(instr), .pc_sel(pc_sel), .wd_sel(wd_sel), .rb_from_rc(rb_from_rc),
    .exc_dst(exc_dst), .rf_we(rf_we), .a_from_pc(a_from_pc),
    .b_from_const(b_from_const), .mem_we(mem_we), .maddr_from_alu(maddr_from_alu),
    .instr_load(instr_load), .alu_fn(alu_fn), .ra(ra), .rb(rb), .rc(rc),
    .vec_irq(vec_irq), .flag_we(flag_we)
  );

  // {pc_sel, wd_sel, rb_from_rc, exc_dst, rf_we, a_from_pc, b_from_const,
  //  mem_we, maddr_from_alu, instr_load, vec_irq, flag_we}
  function automatic logic [13:0] pack(input logic [1:0] p, input logic [1:0] w,
      input logic rbc, input logic exd, input logic rwe, input logic apc,
      input logic bc, input logic mwe, input logic mad, input logic il,
      input logic vi, input logic fw);
    return {p, w, rbc, exd, rwe, apc, bc, mwe, mad, il, vi, fw};
  endfunction

  task automatic step(input logic r, input logic q, input logic cn,
                      input logic z, input logic [15:0] ins);
    logic [13:0] e, a;
    string tag;
    int nph;
    bit nfl;
    @(negedge clk);
    rst = r; irq = q; const_need = cn; zero_a = z; instr = ins;
    nph = 0; nfl = fl_m;
    if (r) begin
      tag = "R1"; e = pack(2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); nfl = 0;
    end else if (ph_m == 0 && q && !fl_m) begin
      tag = "R9"; e = pack(2, 3, 0, 1, 1, 0, 0, 0, 0, 0, 1, 1); nfl = 1;
    end else if (ph_m == 0) begin
      tag = q ? "R10" : "R2";
      e = pack(cn ? 2'd1 : 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
      nph = cn ? 1 : 2;
    end else if (ph_m == 1) begin
      tag = q ? "R10" : "R3"; e = '0; nph = 2;
    end else if (!ins[9]) begin
      tag = "R4"; e = pack(1, 1, 0, 0, 1, 0, ins[10], 0, 0, 0, 0, 0);
    end else begin
      case (ins[8:6])
        3'b000: begin
          tag = "R8";
          e = pack(3, 0, 0, 0, 1, 0, ins[10], 0, 0, 0, 0, ins[2:0] == 3'd6);
          if (ins[2:0] == 3'd6) nfl = 0;
        end
        3'b010: begin tag = "R6"; e = pack(1, 2, 0, 0, 1, 0, 1, 0, 1, 0, 0, 0); end
        3'b110: begin tag = "R6"; e = pack(1, 2, 0, 0, 1, 1, 1, 0, 1, 0, 0, 0); end
        3'b011: begin tag = "R6"; e = pack(1, 0, 1, 0, 0, 0, 1, 1, 1, 0, 0, 0); end
        3'b100: begin tag = "R7"; e = pack(z ? 2'd3 : 2'd1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0); end
        3'b101: begin tag = "R7"; e = pack(z ? 2'd1 : 2'd3, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0); end
        default: begin tag = "R11"; e = pack(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); end
      endcase
    end
    #5;
    a = pack(pc_sel, wd_sel, rb_from_rc, exc_dst, rf_we, a_from_pc, b_from_const,
             mem_we, maddr_from_alu, instr_load, vec_irq, flag_we);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s controls act=%b exp=%b (phase %0d flag %0d)", tag, a, e, ph_m, fl_m);
    end
    total++;
    if ({alu_fn, rb, rc, ra} !== {ins[15:11], ins[8:6], ins[5:3], ins[2:0]}) begin
      bad++;
      $display("FAIL R5 fields act=%h exp=%h", {alu_fn, rb, rc, ra},
               {ins[15:11], ins[8:6], ins[5:3], ins[2:0]});
    end
    @(posedge clk);
    ph_m = nph; fl_m = nfl;
  endtask

  function automatic logic [15:0] mk(input logic [4:0] fn, input logic c,
      input logic s, input logic [2:0] b, input logic [2:0] d, input logic [2:0] a);
    return {fn, c, s, b, d, a};
  endfunction

  initial begin
    rst = 1; irq = 0; zero_a = 0; const_need = 0; instr = '0;
    // R1: reset state, including with irq asserted
    step(1, 0, 0, 0, 16'h0000);
    step(1, 1, 1, 1, 16'hFFFF);
    // R2/R4: short ALU instruction
    step(0, 0, 0, 0, mk(5'h03, 0, 0, 3'd2, 3'd1, 3'd0));
    step(0, 0, 0, 0, mk(5'h03, 0, 0, 3'd2, 3'd1, 3'd0));
    // R2/R3/R10/R6: long load, irq during constant phase ignored
    step(0, 0, 1, 0, mk(5'h00, 1, 1, 3'b010, 3'd3, 3'd4));
    step(0, 1, 1, 0, mk(5'h00, 1, 1, 3'b010, 3'd3, 3'd4));
    step(0, 1, 0, 0, mk(5'h00, 1, 1, 3'b010, 3'd3, 3'd4));
    // R6 store and PC-relative load
    for (int k = 0; k < 2; k++) begin
      logic [15:0] w;
      w = mk(5'h00, 1, 1, k == 0 ? 3'b011 : 3'b110, 3'd5, 3'd1);
      step(0, 0, 1, 0, w); step(0, 0, 0, 0, w); step(0, 0, 0, 0, w);
    end
    // R7 branches with both zero values
    for (int k = 0; k < 4; k++) begin
      logic [15:0] w;
      w = mk(5'h00, 1, 1, k < 2 ? 3'b100 : 3'b101, 3'd7, 3'd2);
      step(0, 0, 1, 0, w); step(0, 0, 0, 0, w); step(0, 0, 0, k[0], w);
    end
    // R11 undefined codes
    step(0, 0, 0, 0, mk(5'h1F, 0, 1, 3'b001, 3'd2, 3'd2));
    step(0, 0, 0, 0, mk(5'h1F, 0, 1, 3'b001, 3'd2, 3'd2));
    step(0, 0, 0, 0, mk(5'h1F, 0, 1, 3'b111, 3'd2, 3'd2));
    step(0, 0, 0, 0, mk(5'h1F, 0, 1, 3'b111, 3'd2, 3'd2));
    // R9 accept, R10 ignored while flag set, R8 jump via R6 clears, accept again
    step(0, 1, 0, 0, 16'h0000);
    step(0, 1, 0, 0, mk(5'h00, 0, 1, 3'b000, 3'd0, 3'd6));
    step(0, 1, 0, 0, mk(5'h00, 0, 1, 3'b000, 3'd0, 3'd6));
    step(0, 1, 0, 0, 16'h0000);
    // R8 jump through another register keeps flag set
    step(0, 1, 0, 0, mk(5'h00, 1, 1, 3'b000, 3'd1, 3'd3));
    step(0, 0, 0, 0, mk(5'h00, 1, 1, 3'b000, 3'd1, 3'd3));
    step(0, 1, 0, 0, 16'h1234);
    // constrained random run
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] w;
      logic [31:0] rv;
      rv = $urandom;
      w  = rv[15:0];
      if (rv[16]) w[8:6] = 3'b000;
      if (rv[17]) w[2:0] = 3'd6;
      step(rv[31:26] == 0, rv[20:18] == 0, rv[21], rv[22], w);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule